// File: doc/BRIEF.md
# Integer Twin Butterfly Multiplier

This block computes one butterfly step of an integer transform in a single issue. From two signed operands `a` and `b` and a signed coefficient `c` it forms the sum and the difference of the operands and multiplies each by the same coefficient. Each product is then scaled down by a power of two, rounding to nearest. Rounding adds half of the last kept bit, then shifts right arithmetically by `n` places. A typical transform kernel uses `n = 14`.

The two results come out together with a pair of destination register indices. The sum-path result goes to the named destination `rt`. The difference-path result goes to the register directly after it. An issue that carries the reserved record bit set produces no write. It is reported as an illegal instruction instead. The datapath is a fixed two-stage pipeline that accepts a new issue every cycle.

Top module: `twin_bfly_mul`

## Requirements
- R1: `out_res_t` equals the rounded, scaled value of `(a + b) * c`, with `a`, `b` and `c` read as XLEN-bit two's-complement numbers. The sum is formed at XLEN+1 bits.
- R2: `out_res_s` equals the rounded, scaled value of `(a - b) * c`. It uses the same operand values as R1 and comes out in the same cycle.
- R3: Scaling works in two steps. With `n > 0`, 2^(n-1) is added to the product, with no loss from a carry out of the top bit. The sum is then shifted right arithmetically by `n`, and the vacated upper bits take the sign. With `n = 0` the product passes through unchanged.
- R4: The product used by R3 is the low XLEN bits of the full signed product, read as a signed XLEN-bit value.
- R5: The shift amount `in_sh` is a 5-bit unsigned field covering 0 to 31. `in_rt` is a 5-bit register index.
- R6: `out_idx_t` equals the issued `rt`. `out_idx_s` equals `rt + 1` modulo 32, so `rt = 31` gives 0.
- R7: An issue with `in_rc = 1` comes out with `out_valid = 1`, `out_illegal = 1`, `out_wen = 0`, and both results equal to zero.
- R8: `in_ready` is always 1. Each cycle with `in_valid = 1` yields exactly one cycle with `out_valid = 1`, two clock edges later. When `out_valid = 0`, both `out_wen` and `out_illegal` are 0. A legal issue gives `out_wen = 1`.
- R9: While reset is held and after its release, `out_valid`, `out_wen` and `out_illegal` are 0 until the first issue arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An issue is presented this cycle |
| in_ready | output | 1 | Always 1: an issue is accepted every cycle |
| in_a | input | XLEN | First operand, signed |
| in_b | input | XLEN | Second operand, signed |
| in_coef | input | XLEN | Coefficient, signed |
| in_rt | input | 5 | Destination register index |
| in_sh | input | 5 | Scaling shift amount n |
| in_rc | input | 1 | Reserved record bit; 1 makes the issue illegal |
| out_valid | output | 1 | Result pair present this cycle |
| out_wen | output | 1 | Write both results to the register pair |
| out_illegal | output | 1 | The issue was illegal |
| out_idx_t | output | 5 | Index for the sum-path result |
| out_idx_s | output | 5 | Index for the difference-path result |
| out_res_t | output | XLEN | Rounded, scaled sum-path product |
| out_res_s | output | XLEN | Rounded, scaled difference-path product |

## Verification
The bench uses small odd products at `n = 1` to test rounding for negative values. A logical shift would show up there as a large positive number, and truncation as a result one too small. It also checks `n = 0`, where a design that builds the constant as `1 << (n-1)` would add a stray bit, and `n = 31`. Operands at the most negative and most positive values exercise the wrap of the product's low half. A destination of 31 exposes an index pair that fails to wrap. Random operands, shifts and valid gaps run back to back to catch a pipeline that drops an issue, delays one, or returns results for a reserved issue.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
    localparam int IDX_W = 5;
    localparam int SH_W  = 5;
    localparam int NPATH = 2;
endpackage

// File: rtl/tbm_prod_path.sv
module tbm_prod_path #(
    parameter int XLEN     = 64,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] coef,
    output logic [XLEN-1:0] prod_lo
);
    localparam int EW = XLEN + 1;

    logic signed [EW-1:0] ext_a;
    logic signed [EW-1:0] ext_b;
    logic signed [EW-1:0] ext_c;
    logic signed [EW-1:0] comb;

    assign ext_a = {op_a[XLEN-1], op_a};
    assign ext_b = {op_b[XLEN-1], op_b};
    assign ext_c = {coef[XLEN-1], coef};

    // widened operand combination: no overflow before the multiply
    generate
        if (SUBTRACT) begin : g_dif
            assign comb = ext_a - ext_b;
        end else begin : g_sum
            assign comb = ext_a + ext_b;
        end
    endgenerate

    // only the low XLEN bits of the signed product are kept
    assign prod_lo = XLEN'(comb * ext_c);
endmodule

// File: rtl/tbm_round_shift.sv
module tbm_round_shift #(
    parameter int XLEN = 64,
    parameter int SH_W = tbm_pkg::SH_W
) (
    input  logic [XLEN-1:0] value,
    input  logic [SH_W-1:0] shamt,
    output logic [XLEN-1:0] result
);
    localparam int EW = XLEN + 1;

    logic [EW-1:0]        ext_v;
    logic [EW-1:0]        half;
    logic [EW-1:0]        acc;
    logic signed [EW-1:0] shifted;

    always_comb begin
        ext_v = {value[XLEN-1], value};
        // zero shift: no rounding constant at all
        if (shamt == '0) begin
            half = '0;
        end else begin
            half = EW'(1) << (shamt - SH_W'(1));
        end
        acc     = ext_v + half;
        shifted = $signed(acc) >>> shamt;
        result  = XLEN'(shifted);
    end
endmodule

// File: rtl/twin_bfly_mul.sv
module twin_bfly_mul #(
    parameter int XLEN = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [XLEN-1:0]          in_a,
    input  logic [XLEN-1:0]          in_b,
    input  logic [XLEN-1:0]          in_coef,
    input  logic [tbm_pkg::IDX_W-1:0] in_rt,
    input  logic [tbm_pkg::SH_W-1:0]  in_sh,
    input  logic                     in_rc,
    output logic                     out_valid,
    output logic                     out_wen,
    output logic                     out_illegal,
    output logic [tbm_pkg::IDX_W-1:0] out_idx_t,
    output logic [tbm_pkg::IDX_W-1:0] out_idx_s,
    output logic [XLEN-1:0]          out_res_t,
    output logic [XLEN-1:0]          out_res_s
);
    import tbm_pkg::*;

    localparam int P_SUM = 0;
    localparam int P_DIF = 1;

    typedef struct packed {
        logic                        valid;
        logic                        illegal;
        logic [IDX_W-1:0]            rt;
        logic [SH_W-1:0]             sh;
        logic [NPATH-1:0][XLEN-1:0]  prod;
    } mul_st_t;

    typedef struct packed {
        logic                        valid;
        logic                        illegal;
        logic                        wen;
        logic [IDX_W-1:0]            idx_t;
        logic [IDX_W-1:0]            idx_s;
        logic [NPATH-1:0][XLEN-1:0]  res;
    } out_st_t;

    mul_st_t mul_d, mul_q;
    out_st_t out_d, out_q;

    logic [NPATH-1:0][XLEN-1:0] prod_w;
    logic [NPATH-1:0][XLEN-1:0] rnd_w;

    generate
        for (genvar g = 0; g < NPATH; g++) begin : g_path
            tbm_prod_path #(
                .XLEN     (XLEN),
                .SUBTRACT (g == P_DIF)
            ) u_prod (
                .op_a    (in_a),
                .op_b    (in_b),
                .coef    (in_coef),
                .prod_lo (prod_w[g])
            );

            tbm_round_shift #(
                .XLEN (XLEN),
                .SH_W (SH_W)
            ) u_rnd (
                .value  (mul_q.prod[g]),
                .shamt  (mul_q.sh),
                .result (rnd_w[g])
            );
        end
    endgenerate

    always_comb begin
        // stage 1: operand formation and multiply
        mul_d.valid   = in_valid;
        mul_d.illegal = in_valid & in_rc;
        mul_d.rt      = in_rt;
        mul_d.sh      = in_sh;
        mul_d.prod    = prod_w;

        // stage 2: rounding, shifting, index pair
        out_d.valid   = mul_q.valid;
        out_d.illegal = mul_q.illegal;
        out_d.wen     = mul_q.valid & ~mul_q.illegal;
        out_d.idx_t   = mul_q.rt;
        out_d.idx_s   = mul_q.rt + IDX_W'(1);
        if (mul_q.illegal) begin
            out_d.res = '0;
        end else begin
            out_d.res = rnd_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_q <= '0;
            out_q <= '0;
        end else begin
            mul_q <= mul_d;
            out_q <= out_d;
        end
    end

    assign in_ready    = 1'b1;
    assign out_valid   = out_q.valid;
    assign out_wen     = out_q.wen;
    assign out_illegal = out_q.illegal;
    assign out_idx_t   = out_q.idx_t;
    assign out_idx_s   = out_q.idx_s;
    assign out_res_t   = out_q.res[P_SUM];
    assign out_res_s   = out_q.res[P_DIF];
endmodule

// File: rtl/twin_bfly_chk.sv
module twin_bfly_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [4:0]      in_rt,
    input logic            in_rc,
    input logic            out_valid,
    input logic            out_wen,
    input logic            out_illegal,
    input logic [4:0]      out_idx_t,
    input logic [4:0]      out_idx_s,
    input logic [XLEN-1:0] out_res_t,
    input logic [XLEN-1:0] out_res_s
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_LAT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);                                   // R8
    AST_LAT_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && out_valid) |-> $past(in_valid, 2));          // R8
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wen && !out_illegal));                    // R8
    AST_IDX_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx_s == 5'(out_idx_t + 5'd1)));            // R6
    AST_IDX_RT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_idx_t == $past(in_rt, 2)));              // R5
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rc) |-> ##2 (out_illegal && !out_wen));        // R7
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_res_t == '0 && out_res_s == '0));         // R7
endmodule

bind twin_bfly_mul twin_bfly_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_twin_bfly_mul.sv
module sim_twin_bfly_mul;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [XLEN-1:0] in_a = '0, in_b = '0, in_coef = '0;
    logic [4:0]      in_rt = '0, in_sh = '0;
    logic            in_rc = 1'b0;
    logic            out_valid, out_wen, out_illegal;
    logic [4:0]      out_idx_t, out_idx_s;
    logic [XLEN-1:0] out_res_t, out_res_s;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic            v;
        logic            ill;
        logic [4:0]      it;
        logic [4:0]      is;
        logic [XLEN-1:0] rt_res;
        logic [XLEN-1:0] rs_res;
    } exp_t;

    exp_t h1, h2;

    always #5 clk = ~clk;

    twin_bfly_mul #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_coef(in_coef), .in_rt(in_rt),
        .in_sh(in_sh), .in_rc(in_rc), .out_valid(out_valid), .out_wen(out_wen),
        .out_illegal(out_illegal), .out_idx_t(out_idx_t), .out_idx_s(out_idx_s),
        .out_res_t(out_res_t), .out_res_s(out_res_s)
    );

    function automatic logic [XLEN-1:0] ref_bfly(logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                                                 logic [XLEN-1:0] c, logic [4:0] n, bit sub);
        logic signed [XLEN:0]     s;
        logic signed [2*XLEN+1:0] p;
        logic signed [XLEN+1:0]   lo;
        logic signed [XLEN+1:0]   t;
        if (sub) s = $signed({a[XLEN-1], a}) - $signed({b[XLEN-1], b});
        else     s = $signed({a[XLEN-1], a}) + $signed({b[XLEN-1], b});
        p  = s * $signed(c);
        lo = $signed(p[XLEN-1:0]);
        t  = lo;
        if (n != 0) t = t + ((XLEN+2)'(1) <<< (n - 1));
        t = t >>> n;
        return t[XLEN-1:0];
    endfunction

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_out();
        chk("R8 in_ready", XLEN'(in_ready), XLEN'(1));
        chk("R8 out_valid", XLEN'(out_valid), XLEN'(h2.v));
        if (h2.v) begin
            chk("R7 out_illegal", XLEN'(out_illegal), XLEN'(h2.ill));
            chk("R8 out_wen", XLEN'(out_wen), XLEN'(!h2.ill));
            chk("R5 out_idx_t", XLEN'(out_idx_t), XLEN'(h2.it));
            chk("R6 out_idx_s", XLEN'(out_idx_s), XLEN'(h2.is));
            chk("R1 out_res_t", out_res_t, h2.rt_res);
            chk("R2 out_res_s", out_res_s, h2.rs_res);
        end else begin
            chk("R8 idle wen", XLEN'(out_wen), '0);
            chk("R8 idle illegal", XLEN'(out_illegal), '0);
        end
    endtask

    // called at a falling edge; outputs now reflect the issue of two steps ago
    task automatic step(input logic v, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                        input logic [XLEN-1:0] c, input logic [4:0] rt,
                        input logic [4:0] sh, input logic rc);
        exp_t e;
        check_out();
        e.v      = v;
        e.ill    = rc;
        e.it     = rt;
        e.is     = 5'(rt + 5'd1);
        e.rt_res = rc ? '0 : ref_bfly(a, b, c, sh, 1'b0);
        e.rs_res = rc ? '0 : ref_bfly(a, b, c, sh, 1'b1);
        h2 = h1;
        h1 = e;
        in_valid = v; in_a = a; in_b = b; in_coef = c;
        in_rt = rt; in_sh = sh; in_rc = rc;
        @(negedge clk);
    endtask

    function automatic logic [XLEN-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] MAXV = {1'b0, {(XLEN-1){1'b1}}};

    initial begin
        void'($urandom(32'd7321));
        h1 = '{v: 0, ill: 0, it: 0, is: 0, rt_res: 0, rs_res: 0};
        h2 = h1;
        repeat (3) @(negedge clk);
        // R9: quiet during reset
        chk("R9 reset valid", XLEN'(out_valid), '0);
        chk("R9 reset wen", XLEN'(out_wen), '0);
        chk("R9 reset illegal", XLEN'(out_illegal), '0);
        rst_n = 1'b1;
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 0);
        // R1 R2: typical transform scaling
        step(1, 64'd100, 64'd30, 64'd11585, 5'd3, 5'd14, 0);
        // R3: n = 0 passes the product through
        step(1, 64'd5, -64'sd2, 64'd7, 5'd4, 5'd0, 0);
        // R3: rounding of odd products, both signs
        step(1, 64'd3, 64'd0, 64'd1, 5'd5, 5'd1, 0);
        step(1, -64'sd3, 64'd0, 64'd1, 5'd6, 5'd1, 0);
        step(1, -64'sd5, 64'd2, 64'd1, 5'd7, 5'd2, 0);
        // R3: largest shift
        step(1, MAXV, 64'd1, 64'd3, 5'd8, 5'd31, 0);
        // R4: extreme operands wrap in the low half
        step(1, MINV, MINV, -64'sd1, 5'd9, 5'd1, 0);
        step(1, MINV, MAXV, 64'd3, 5'd10, 5'd0, 0);
        step(1, MAXV, MAXV, MAXV, 5'd11, 5'd17, 0);
        // R6: destination wrap
        step(1, 64'd9, 64'd4, 64'd2, 5'd31, 5'd1, 0);
        // R7: reserved record bit
        step(1, 64'd9, 64'd4, 64'd2, 5'd12, 5'd1, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R5 R8: random, back to back with gaps
        for (int i = 0; i < 800; i++) begin
            logic [XLEN-1:0] ra, rb, rc_v;
            ra = rnd64(); rb = rnd64(); rc_v = rnd64();
            if ($urandom_range(0, 3) == 0) rc_v = XLEN'($signed(rc_v[15:0]));
            if ($urandom_range(0, 9) == 0) ra = MINV;
            if ($urandom_range(0, 9) == 0) rb = MAXV;
            step($urandom_range(0, 9) < 7, ra, rb, rc_v, 5'($urandom_range(0, 31)),
                 5'($urandom_range(0, 31)), $urandom_range(0, 15) == 0);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule